// File: doc/BRIEF.md
# SDRAM Mode Register and Burst Column Sequencer

This block holds the operating mode of a synchronous DRAM device and turns each read or write burst start into a sequence of column addresses. A mode-register-set command carries a mode word on the address bits. The block checks that word and loads it. The word selects the burst length (1, 2, 4, 8 beats or a full page), the column ordering (sequential or interleaved), the CAS latency (2 or 3) and a write mode that forces single-location writes. The CAS latency and the write mode are driven straight to the datapath.

A burst starts with a start column and a bank on the start stream. The column addresses then leave on an output stream at one beat per clock. The consumer can hold any beat. The start stream is valid/ready: `start_ready` is high only while the mode is settled and no burst is running, and a start counts on a cycle where both `start_valid` and `start_ready` are high. The column stream is valid/ready as well: `col_valid` stays high and `col_addr` stays stable until `col_ready` takes the beat. A burst-terminate command, or a precharge aimed at the bursting bank (or at all banks), ends the burst. After the terminating edge `col_valid` is low.

Top module: `sdram_mode_burst_seq`

## Requirements
- R1: After reset, `mode_ready` is 1, `cas_lat` is 2, `single_write` is 0, `col_valid` is 0 and `mrs_error` is 0. The reset burst length is 1 with sequential order.
- R2: An accepted mode-register-set loads CAS latency from word bits 6..4. Code 010 gives `cas_lat`=2 and code 011 gives `cas_lat`=3. The new value is visible after the command's clock edge.
- R3: Word bits 2..0 set the burst length: 000=1, 001=2, 010=4, 011=8 beats. `col_last` is high on the final beat only. After that beat is taken, `col_valid` is low.
- R4: When word bit 3 is 0 (sequential), beat i carries the start column with its low log2(BL) bits replaced by (start low bits + i) mod BL. The upper bits are unchanged.
- R5: When word bit 3 is 1 (interleaved), beat i carries the start column XOR i.
- R6: Burst code 111 with bit 3 = 0 is a full-page burst. Beat i is (start + i) mod 512. The burst wraps from 511 to 0, never raises `col_last`, and runs until it is terminated.
- R7: Word bit 9 = 1 sets `single_write`. Every write burst is then one beat, and read bursts keep the programmed length. Bit 9 = 0 clears `single_write`.
- R8: A mode-register-set is rejected if any of these holds: the burst code is 100, 101 or 110; the code is 111 with bit 3 = 1; the latency code is neither 010 nor 011; bits 8..7 are not 00; `banks_idle` is low; or `mode_ready` is low. On a reject, `mrs_error` is high for the one cycle after the edge and every mode field keeps its value.
- R9: After an accepted mode-register-set, `mode_ready` is low for exactly TRSC cycles (default 2).
- R10: `burst_term`, or `pre_cmd` with `pre_all` = 1 or `pre_bank` equal to the burst bank, ends the burst at that edge. A precharge to a different bank has no effect on the burst.
- R11: While `col_valid` is high and `col_ready` is low, `col_valid` stays high and `col_addr` is unchanged. The burst moves on only when a beat is taken.
- R12: `start_ready` equals `mode_ready` and no burst running. A start taken on a handshake gives `col_valid` = 1 after that edge, with `col_bank` set to the start bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mrs_valid | input | 1 | Mode-register-set command strobe |
| mrs_word | input | 10 | Mode word (address bits 9..0) |
| banks_idle | input | 1 | All banks idle |
| mrs_error | output | 1 | Rejected mode-register-set, one-cycle pulse |
| mode_ready | output | 1 | Mode settled; commands may follow |
| cas_lat | output | 3 | Programmed CAS latency (2 or 3) |
| single_write | output | 1 | Writes are single-beat |
| start_valid | input | 1 | Burst start request |
| start_ready | output | 1 | Burst start can be taken |
| start_write | input | 1 | Burst is a write |
| start_col | input | 9 | Start column |
| start_bank | input | 2 | Bank of the burst |
| burst_term | input | 1 | Burst-terminate command |
| pre_cmd | input | 1 | Precharge command |
| pre_all | input | 1 | Precharge targets all banks |
| pre_bank | input | 2 | Precharge bank |
| col_valid | output | 1 | Column beat valid |
| col_ready | input | 1 | Consumer takes the beat |
| col_addr | output | 9 | Column address of the beat |
| col_bank | output | 2 | Bank of the beat |
| col_last | output | 1 | Final beat of a fixed-length burst |

## Verification
Sequential bursts use start columns that are not aligned to the block. This separates a wrap inside the aligned block from a plain increment that carries into the upper bits. Interleaved bursts use the same length as a sequential one but start on an odd column, where XOR order and additive order give different sequences. A full-page burst starts three columns below the top of the page, to show the wrap to column 0 and the absence of a last marker. Reject cases each break one mode-word rule at a time, and a burst follows them to show that the stored length survived. Precharge to a foreign bank is set beside precharge to the active bank to show that the bank match decides termination.

// File: rtl/sdram_mode_pkg.sv
package sdram_mode_pkg;

  typedef struct packed {
    logic [2:0] bl;
    logic       interleave;
    logic [2:0] cl;
    logic       single_wr;
  } mode_t;

  localparam mode_t MODE_RESET = '{bl: 3'b000, interleave: 1'b0, cl: 3'b010, single_wr: 1'b0};

  function automatic logic word_legal(input logic [9:0] w);
    logic bl_ok;
    logic cl_ok;
    bl_ok = (w[2] == 1'b0) || (w[2:0] == 3'b111 && w[3] == 1'b0);
    cl_ok = (w[6:4] == 3'b010) || (w[6:4] == 3'b011);
    return bl_ok && cl_ok && (w[8:7] == 2'b00);
  endfunction

  function automatic mode_t decode_word(input logic [9:0] w);
    mode_t m;
    m.bl         = w[2:0];
    m.interleave = w[3];
    m.cl         = w[6:4];
    m.single_wr  = w[9];
    return m;
  endfunction

endpackage

// File: rtl/sdram_mode_reg.sv
module sdram_mode_reg
  import sdram_mode_pkg::*;
#(
  parameter int TRSC = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mrs_valid,
  input  logic [9:0] mrs_word,
  input  logic       banks_idle,
  output mode_t      mode,
  output logic       mrs_error,
  output logic       mode_ready
);

  localparam int TW = (TRSC > 0) ? $clog2(TRSC + 1) : 1;

  logic  accept;
  mode_t mode_q;

  assign accept = mrs_valid && banks_idle && mode_ready && word_legal(mrs_word);
  assign mode   = mode_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q    <= MODE_RESET;
      mrs_error <= 1'b0;
    end else begin
      mrs_error <= mrs_valid && !accept;
      if (accept) mode_q <= decode_word(mrs_word);
    end
  end

  generate
    if (TRSC == 0) begin : g_no_wait
      assign mode_ready = 1'b1;
    end else begin : g_wait
      logic [TW-1:0] wait_q;
      always_ff @(posedge clk) begin
        if (!rst_n)              wait_q <= '0;
        else if (accept)         wait_q <= TW'(TRSC);
        else if (wait_q != '0)   wait_q <= wait_q - 1'b1;
      end
      assign mode_ready = (wait_q == '0);

      assert_settle_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !mode_ready);
    end
  endgenerate

  assert_keep_on_reject_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mrs_error |-> $stable(mode_q));
  assert_cl_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q.cl == 3'b010) || (mode_q.cl == 3'b011));
  assert_page_seq_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q.bl == 3'b111) |-> !mode_q.interleave);

endmodule

// File: rtl/sdram_burst_gen.sv
module sdram_burst_gen
  import sdram_mode_pkg::*;
#(
  parameter int COL_W  = 9,
  parameter int BANK_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  mode_t             mode,
  input  logic              start_fire,
  input  logic              start_write,
  input  logic [COL_W-1:0]  start_col,
  input  logic [BANK_W-1:0] start_bank,
  input  logic              burst_term,
  input  logic              pre_cmd,
  input  logic              pre_all,
  input  logic [BANK_W-1:0] pre_bank,
  input  logic              col_ready,
  output logic              busy,
  output logic [COL_W-1:0]  col_addr,
  output logic [BANK_W-1:0] col_bank,
  output logic              col_last
);

  localparam logic [COL_W-1:0] ONE = {{(COL_W-1){1'b0}}, 1'b1};

  logic [COL_W-1:0]  base_q, cnt_q, mask_q, mask_n, seq_sum;
  logic [BANK_W-1:0] bank_q;
  logic              page_q, inter_q, one_beat, kill, fire;

  assign one_beat = start_write && mode.single_wr;
  assign mask_n   = one_beat ? '0 : (ONE << mode.bl[1:0]) - ONE;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      base_q  <= '0;
      cnt_q   <= '0;
      mask_q  <= '0;
      bank_q  <= '0;
      page_q  <= 1'b0;
      inter_q <= 1'b0;
    end else if (start_fire) begin
      busy    <= 1'b1;
      base_q  <= start_col;
      cnt_q   <= '0;
      mask_q  <= mask_n;
      bank_q  <= start_bank;
      page_q  <= (mode.bl == 3'b111) && !one_beat;
      inter_q <= mode.interleave;
    end else if (kill) begin
      busy    <= 1'b0;
    end else if (fire) begin
      if (col_last) busy  <= 1'b0;
      else          cnt_q <= cnt_q + 1'b1;
    end
  end

  assign kill    = busy && (burst_term || (pre_cmd && (pre_all || pre_bank == bank_q)));
  assign fire    = busy && col_ready;
  assign seq_sum = base_q + cnt_q;

  always_comb begin
    if (page_q)       col_addr = seq_sum;
    else if (inter_q) col_addr = base_q ^ cnt_q;
    else              col_addr = (base_q & ~mask_q) | (seq_sum & mask_q);
  end

  assign col_bank = bank_q;
  assign col_last = busy && !page_q && (cnt_q == mask_q);

  assert_hold_beat_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !col_ready && !kill) |=> (busy && $stable(col_addr)));
  assert_end_after_last_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && col_last) |=> !busy);
  assert_kill_ends_R10: assert property (@(posedge clk) disable iff (!rst_n)
    kill |=> !busy);

endmodule

// File: rtl/sdram_mode_burst_seq.sv
module sdram_mode_burst_seq
  import sdram_mode_pkg::*;
#(
  parameter int TRSC   = 2,
  parameter int COL_W  = 9,
  parameter int BANK_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mrs_valid,
  input  logic [9:0]        mrs_word,
  input  logic              banks_idle,
  output logic              mrs_error,
  output logic              mode_ready,
  output logic [2:0]        cas_lat,
  output logic              single_write,
  input  logic              start_valid,
  output logic              start_ready,
  input  logic              start_write,
  input  logic [COL_W-1:0]  start_col,
  input  logic [BANK_W-1:0] start_bank,
  input  logic              burst_term,
  input  logic              pre_cmd,
  input  logic              pre_all,
  input  logic [BANK_W-1:0] pre_bank,
  output logic              col_valid,
  input  logic              col_ready,
  output logic [COL_W-1:0]  col_addr,
  output logic [BANK_W-1:0] col_bank,
  output logic              col_last
);

  mode_t mode;
  logic  busy, start_fire;

  sdram_mode_reg #(.TRSC(TRSC)) u_mode (
    .clk        (clk),
    .rst_n      (rst_n),
    .mrs_valid  (mrs_valid),
    .mrs_word   (mrs_word),
    .banks_idle (banks_idle),
    .mode       (mode),
    .mrs_error  (mrs_error),
    .mode_ready (mode_ready)
  );

  assign start_ready  = mode_ready && !busy;
  assign start_fire   = start_valid && start_ready;
  assign cas_lat      = mode.cl;
  assign single_write = mode.single_wr;
  assign col_valid    = busy;

  sdram_burst_gen #(.COL_W(COL_W), .BANK_W(BANK_W)) u_burst (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode        (mode),
    .start_fire  (start_fire),
    .start_write (start_write),
    .start_col   (start_col),
    .start_bank  (start_bank),
    .burst_term  (burst_term),
    .pre_cmd     (pre_cmd),
    .pre_all     (pre_all),
    .pre_bank    (pre_bank),
    .col_ready   (col_ready),
    .busy        (busy),
    .col_addr    (col_addr),
    .col_bank    (col_bank),
    .col_last    (col_last)
  );

  assert_start_opens_R12: assert property (@(posedge clk) disable iff (!rst_n)
    start_fire |=> (col_valid && col_bank == $past(start_bank)));
  assert_last_is_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
    col_last |-> col_valid);

endmodule

// File: tb/test_sdram_mode_burst_seq.sv
module test_sdram_mode_burst_seq;

  localparam int TRSC = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mrs_valid = 1'b0, banks_idle = 1'b1;
  logic [9:0] mrs_word = '0;
  logic       mrs_error, mode_ready, single_write;
  logic [2:0] cas_lat;
  logic       start_valid = 1'b0, start_write = 1'b0, start_ready;
  logic [8:0] start_col = '0;
  logic [1:0] start_bank = '0, pre_bank = '0, col_bank;
  logic       burst_term = 1'b0, pre_cmd = 1'b0, pre_all = 1'b0;
  logic       col_valid, col_ready = 1'b1, col_last;
  logic [8:0] col_addr;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  sdram_mode_burst_seq #(.TRSC(TRSC)) i_sdram_mode_burst_seq (
    .clk(clk), .rst_n(rst_n), .mrs_valid(mrs_valid), .mrs_word(mrs_word),
    .banks_idle(banks_idle), .mrs_error(mrs_error), .mode_ready(mode_ready),
    .cas_lat(cas_lat), .single_write(single_write), .start_valid(start_valid),
    .start_ready(start_ready), .start_write(start_write), .start_col(start_col),
    .start_bank(start_bank), .burst_term(burst_term), .pre_cmd(pre_cmd),
    .pre_all(pre_all), .pre_bank(pre_bank), .col_valid(col_valid),
    .col_ready(col_ready), .col_addr(col_addr), .col_bank(col_bank),
    .col_last(col_last)
  );

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [9:0] mw(input int bl, input int bt, input int cl, input int wm);
    return {1'(wm), 2'b00, 3'(cl), 1'(bt), 3'(bl)};
  endfunction

  function automatic int exp_col(input int base, input int i, input int beats,
                                 input bit inter, input bit page);
    int lo;
    if (page) return (base + i) % 512;
    if (inter) return base ^ i;
    lo = base % beats;
    return base - lo + ((lo + i) % beats);
  endfunction

  task automatic mrs(input logic [9:0] w, input bit idle, input bit exp_err, input string req);
    mrs_valid = 1'b1; mrs_word = w; banks_idle = idle;
    tick();
    mrs_valid = 1'b0; banks_idle = 1'b1;
    check({req, " error flag"}, mrs_error, exp_err);
    if (!exp_err) begin
      for (int k = 0; k < TRSC; k++) begin
        check("R9 ready low", mode_ready, 0);
        check("R12 start_ready low while settling", start_ready, 0);
        tick();
      end
      check("R9 ready back", mode_ready, 1);
    end else begin
      tick();
      check({req, " error pulse ends"}, mrs_error, 0);
    end
  endtask

  task automatic start(input int col, input int bank, input bit wr);
    start_valid = 1'b1; start_col = 9'(col); start_bank = 2'(bank); start_write = wr;
    check("R12 start_ready idle", start_ready, 1);
    tick();
    start_valid = 1'b0;
    check("R12 valid after start", col_valid, 1);
    check("R12 bank", col_bank, bank);
  endtask

  task automatic burst(input int col, input int bank, input bit wr, input int beats,
                       input bit inter, input bit page, input int run, input string req);
    col_ready = 1'b1;
    start(col, bank, wr);
    for (int i = 0; i < run; i++) begin
      check({req, " valid"}, col_valid, 1);
      check({req, " addr"}, col_addr, exp_col(col, i, beats, inter, page));
      check({req, " last"}, col_last, (!page && i == beats - 1) ? 1 : 0);
      tick();
    end
    if (!page) check({req, " ends R3"}, col_valid, 0);
  endtask

  task automatic t_reset();
    check("R1 ready", mode_ready, 1);
    check("R1 cas_lat", cas_lat, 2);
    check("R1 single_write", single_write, 0);
    check("R1 col_valid", col_valid, 0);
    check("R1 mrs_error", mrs_error, 0);
    burst(9'h033, 0, 1'b0, 1, 1'b0, 1'b0, 1, "R1 reset BL1");
  endtask

  task automatic t_seq();
    mrs(mw(2, 0, 3, 0), 1'b1, 1'b0, "R2 load CL3 BL4");
    check("R2 cas_lat 3", cas_lat, 3);
    burst(9'h0D6, 1, 1'b0, 4, 1'b0, 1'b0, 4, "R4 seq BL4");
    mrs(mw(3, 0, 2, 0), 1'b1, 1'b0, "R2 load CL2 BL8");
    check("R2 cas_lat 2", cas_lat, 2);
    burst(9'h1FD, 2, 1'b0, 8, 1'b0, 1'b0, 8, "R4 seq BL8 wrap");
    mrs(mw(1, 0, 2, 0), 1'b1, 1'b0, "R3 load BL2");
    burst(9'h011, 3, 1'b0, 2, 1'b0, 1'b0, 2, "R3 seq BL2");
  endtask

  task automatic t_inter();
    mrs(mw(3, 1, 3, 0), 1'b1, 1'b0, "R5 load BL8 interleaved");
    burst(9'h1A5, 0, 1'b0, 8, 1'b1, 1'b0, 8, "R5 interleaved BL8");
    mrs(mw(2, 1, 3, 0), 1'b1, 1'b0, "R5 load BL4 interleaved");
    burst(9'h00B, 1, 1'b1, 4, 1'b1, 1'b0, 4, "R5 interleaved BL4");
  endtask

  task automatic t_page();
    mrs(mw(7, 0, 2, 0), 1'b1, 1'b0, "R6 load page");
    burst(509, 2, 1'b0, 512, 1'b0, 1'b1, 7, "R6 page wrap");
    check("R6 still running", col_valid, 1);
    burst_term = 1'b1;
    tick();
    burst_term = 1'b0;
    check("R10 term ends page", col_valid, 0);
  endtask

  task automatic t_single();
    mrs(mw(2, 0, 3, 1), 1'b1, 1'b0, "R7 load single write");
    check("R7 single_write set", single_write, 1);
    burst(9'h045, 0, 1'b1, 1, 1'b0, 1'b0, 1, "R7 write one beat");
    burst(9'h045, 0, 1'b0, 4, 1'b0, 1'b0, 4, "R7 read full length");
    mrs(mw(2, 0, 3, 0), 1'b1, 1'b0, "R7 clear single write");
    check("R7 single_write clear", single_write, 0);
    burst(9'h045, 0, 1'b1, 4, 1'b0, 1'b0, 4, "R7 write full length");
  endtask

  task automatic t_reject();
    mrs(mw(5, 0, 2, 0), 1'b1, 1'b1, "R8 reserved length");
    mrs(mw(7, 1, 2, 0), 1'b1, 1'b1, "R8 page interleaved");
    mrs(mw(3, 0, 1, 0), 1'b1, 1'b1, "R8 reserved latency");
    mrs(mw(3, 0, 2, 0) | 10'h080, 1'b1, 1'b1, "R8 bit7 set");
    mrs(mw(3, 0, 2, 1), 1'b0, 1'b1, "R8 banks busy");
    check("R8 cas_lat kept", cas_lat, 3);
    check("R8 single_write kept", single_write, 0);
    burst(9'h0F2, 1, 1'b0, 4, 1'b0, 1'b0, 4, "R8 length kept");
    mrs_valid = 1'b1; mrs_word = mw(1, 0, 2, 0);
    tick();
    mrs_word = mw(3, 0, 2, 0);
    check("R8 first accepted", mrs_error, 0);
    tick();
    mrs_valid = 1'b0;
    check("R8 reject while not ready", mrs_error, 1);
    tick(); tick();
    check("R8 latency kept from first", cas_lat, 2);
    burst(9'h0F3, 1, 1'b0, 2, 1'b0, 1'b0, 2, "R8 length from first");
  endtask

  task automatic t_term();
    mrs(mw(3, 0, 3, 0), 1'b1, 1'b0, "R10 load BL8");
    start(9'h020, 1, 1'b0);
    tick();
    pre_cmd = 1'b1; pre_bank = 2'd2;
    tick();
    pre_cmd = 1'b0;
    check("R10 foreign precharge ignored", col_valid, 1);
    check("R10 addr after foreign pre", col_addr, 9'h022);
    pre_cmd = 1'b1; pre_bank = 2'd1;
    tick();
    pre_cmd = 1'b0;
    check("R10 own-bank precharge ends", col_valid, 0);
    start(9'h030, 3, 1'b0);
    pre_cmd = 1'b1; pre_all = 1'b1; pre_bank = 2'd0;
    tick();
    pre_cmd = 1'b0; pre_all = 1'b0;
    check("R10 precharge all ends", col_valid, 0);
  endtask

  task automatic t_backpressure();
    col_ready = 1'b0;
    start(9'h106, 0, 1'b0);
    for (int k = 0; k < 3; k++) begin
      check("R11 held valid", col_valid, 1);
      check("R11 held addr", col_addr, 9'h106);
      tick();
    end
    col_ready = 1'b1;
    tick();
    col_ready = 1'b0;
    check("R11 advanced once", col_addr, 9'h107);
    tick();
    check("R11 held second", col_addr, 9'h107);
    col_ready = 1'b1;
    for (int i = 1; i < 8; i++) begin
      check("R11 resumed addr", col_addr, exp_col(9'h106, i, 8, 1'b0, 1'b0));
      tick();
    end
    check("R11 done", col_valid, 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_seq();
    t_inter();
    t_page();
    t_single();
    t_reject();
    t_term();
    t_backpressure();
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual 1 expected 0");
    finish_run();
  end

endmodule